// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block turns bytes written by a host into asynchronous serial frames on a single line. A one-byte holding register sits in front of a shift register, so the host can queue the next byte while the current frame is still going out. Each frame has one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high.

The bit period comes from an 8-bit divisor `N` and a speed select. With the speed select set (fast), one bit lasts 16·(N+1) clock cycles. With it clear (slow), one bit lasts 64·(N+1) clock cycles. For example, a 3.6864 MHz clock with N=5 in fast mode gives 38400 baud. Two flags report the state of the two registers. `hold_empty` is high when a new byte can be written, and the interrupt request mirrors it. `shift_empty` is high only when nothing remains to send. It is a status flag for polling and raises no interrupt. Clearing the transmit enable aborts any frame and flushes both registers.

The frame controller is a four-state machine:
- ST_IDLE: nothing to send.
- ST_START: driving the start bit.
- ST_DATA: driving the eight data bits.
- ST_STOP: driving the stop bit.

Its transitions are:
- IDLE→START, called the load: the holding register is full.
- START→DATA: at the end of a bit period.
- DATA→DATA: at the end of each bit period, which moves to the next bit.
- DATA→STOP: after the end of bit 7.
- STOP→START, called the back-to-back load: the stop bit ends and the holding register is full.
- STOP→IDLE: the stop bit ends and the holding register is empty.
- Any state→IDLE: the transmit enable is low.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd`=1, `hold_empty`=1, `shift_empty`=1 and `irq`=1.
- R2: With `fast`=1, each bit on `txd` lasts exactly 16·(`divisor`+1) clock cycles.
- R3: With `fast`=0, each bit on `txd` lasts exactly 64·(`divisor`+1) clock cycles.
- R4: A frame consists of the following bits, and `txd` is 1 when idle:
  - one start bit of 0;
  - data bits 0 through 7, with bit 0 first;
  - one stop bit of 1.
- R5: Writing the holding register works as follows:
  - A write (`wr_valid`=1 with `tx_en`=1) while `hold_empty`=1 makes `hold_empty` 0 on the next clock.
  - A write while `hold_empty`=0 is ignored, and the held byte is kept.
- R6: When the shifter is idle, the held byte is loaded one clock after the write. In that same cycle `hold_empty` returns to 1, `shift_empty` falls to 0 and the start bit begins.
- R7: A byte written while a frame is in flight waits in the holding register (`hold_empty`=0) until the last cycle of that frame's stop bit. Its start bit then follows with no gap.
- R8: `shift_empty` stays 0 through the whole frame, including the stop bit. It becomes 1 only in the cycle after the stop bit ends with no byte waiting.
- R9: `irq` equals `hold_empty` at all times.
- R10: When `tx_en`=0, the following hold:
  - On the next clock the frame is aborted, both registers are emptied, both flags read 1 and `txd` is 1.
  - Writes are ignored while `tx_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; low aborts and flushes |
| fast | input | 1 | Speed select: 1 gives 16 clocks per divisor step, 0 gives 64 |
| divisor | input | 8 | Divisor N; bit period is (N+1) times 16 or 64 clocks |
| wr_valid | input | 1 | One-cycle write strobe for the holding register |
| wr_data | input | 8 | Byte to write |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | Shift register empty and last stop bit finished |
| irq | output | 1 | Interrupt request, follows `hold_empty` |

## Verification
Two functions can fall in the same cycle: the end of one frame's stop bit and the hand-off of a waiting byte into the shift register. At that edge `hold_empty` rises, `shift_empty` stays low and the next start bit begins. The bench provokes this by writing a second byte right after the first frame starts, and a third byte while the register is still full. It samples just before and just after the stop-bit boundary. There it expects the line still high with the byte waiting, and then the line low with the holding register freed and the shift register busy.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_STOP
    } tx_state_t;
endpackage

// File: rtl/uart_tx_baud.sv
module uart_tx_baud #(
    parameter int DIV_W    = 8,
    parameter int FAST_OVS = 16,
    parameter int SLOW_OVS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             fast,
    input  logic [DIV_W-1:0] divisor,
    output logic             bit_end
);
    localparam int CNT_W = $clog2(SLOW_OVS) + DIV_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   prod;
    logic [CNT_W-1:0] limit;

    // bit period in clocks = (N+1) * oversampling factor
    always_comb begin
        prod  = ({1'b0, CNT_W'(divisor)} + (CNT_W+1)'(1))
              * (fast ? (CNT_W+1)'(FAST_OVS) : (CNT_W+1)'(SLOW_OVS));
        limit = CNT_W'(prod - (CNT_W+1)'(1));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign bit_end = run && (cnt >= limit);
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    logic accept;

    assign accept = tx_en && wr_valid && !full;

    always_ff @(posedge clk) begin
        if (!rst_n || !tx_en) begin
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (accept) begin
            full <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data <= '0;
        end else if (accept) begin
            data <= wr_data;
        end
    end
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              bit_end,
    input  logic              hold_full,
    input  logic [DATA_W-1:0] hold_data,
    output logic              take,
    output logic              busy,
    output logic              txd,
    output logic              shift_empty
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_t         state, state_n;
    logic [DATA_W-1:0] shreg;
    logic [IDX_W-1:0]  idx;

    // next state and hand-off decision
    always_comb begin
        state_n = state;
        take    = 1'b0;
        if (!tx_en) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (hold_full) begin
                        state_n = ST_START;
                        take    = 1'b1;
                    end
                end
                ST_START: begin
                    if (bit_end) state_n = ST_DATA;
                end
                ST_DATA: begin
                    if (bit_end && idx == LAST_IDX) state_n = ST_STOP;
                end
                ST_STOP: begin
                    if (bit_end) begin
                        if (hold_full) begin
                            state_n = ST_START;
                            take    = 1'b1;
                        end else begin
                            state_n = ST_IDLE;
                        end
                    end
                end
                default: state_n = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // shift register and bit index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            idx   <= '0;
        end else if (take) begin
            shreg <= hold_data;
            idx   <= '0;
        end else if (state == ST_DATA && bit_end) begin
            shreg <= shreg >> 1;
            idx   <= idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        txd         = 1'b1;
        shift_empty = 1'b0;
        busy        = 1'b1;
        unique case (state)
            ST_IDLE: begin
                shift_empty = 1'b1;
                busy        = 1'b0;
            end
            ST_START: txd = 1'b0;
            ST_DATA:  txd = shreg[0];
            ST_STOP:  txd = 1'b1;
            default: begin
                shift_empty = 1'b1;
                busy        = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int FAST_OVS = 16,
    parameter int SLOW_OVS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              fast,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              hold_empty,
    output logic              shift_empty,
    output logic              irq
);
    logic              bit_end;
    logic              busy;
    logic              take;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;

    uart_tx_baud #(
        .DIV_W   (DIV_W),
        .FAST_OVS(FAST_OVS),
        .SLOW_OVS(SLOW_OVS)
    ) i_baud (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .fast   (fast),
        .divisor(divisor),
        .bit_end(bit_end)
    );

    uart_tx_hold #(
        .DATA_W(DATA_W)
    ) i_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_en   (tx_en),
        .wr_valid(wr_valid),
        .wr_data (wr_data),
        .take    (take),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_tx_frame #(
        .DATA_W(DATA_W)
    ) i_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_en      (tx_en),
        .bit_end    (bit_end),
        .hold_full  (hold_full),
        .hold_data  (hold_data),
        .take       (take),
        .busy       (busy),
        .txd        (txd),
        .shift_empty(shift_empty)
    );

    assign hold_empty = !hold_full;
    assign irq        = hold_empty;
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_valid,
    input logic txd,
    input logic hold_empty,
    input logic shift_empty
);
    AST_WRITE_CLEARS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && tx_en && hold_empty) |=> !hold_empty);                 // R5

    AST_HANDOFF_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_en && $past(tx_en) && $rose(hold_empty)) |-> (!shift_empty && !txd)); // R6

    AST_EMPTY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(shift_empty) && $past(tx_en)) |-> $past(txd));               // R8

    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> txd);                                               // R4

    AST_DISABLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (hold_empty && shift_empty && txd));                     // R10
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk i_chk (.*);

// File: tb/test_uart_tx_dbuf.sv
module test_uart_tx_dbuf;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       fast = 1'b1;
    logic [7:0] divisor = 8'd0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       txd, hold_empty, shift_empty, irq;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    uart_tx_dbuf i_uart_tx_dbuf (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .fast(fast),
        .divisor(divisor), .wr_valid(wr_valid), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty), .irq(irq)
    );

    // {fast, divisor, byte}; every byte has bit 0 set so the start bit length is measurable
    localparam logic [16:0] VEC [4] = '{
        {1'b1, 8'd0, 8'h35},
        {1'b1, 8'd2, 8'hC7},
        {1'b0, 8'd0, 8'h81},
        {1'b1, 8'd5, 8'hE9}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // write one byte into an idle block; returns at load+0.5 cycle
    task automatic write_idle(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = b;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(hold_empty == 1'b0, "R5 write clears hold_empty", int'(hold_empty), 0);
        chk(irq == hold_empty, "R9 irq follows hold_empty", int'(irq), int'(hold_empty));
        @(negedge clk);
        chk(txd == 1'b0, "R6 start bit after load", int'(txd), 0);
        chk(hold_empty == 1'b1 && shift_empty == 1'b0, "R6 flags at hand-off",
            int'({hold_empty, shift_empty}), 2);
        chk(irq == 1'b1, "R9 irq high after hand-off", int'(irq), 1);
    endtask

    // entered at load+0.5; leaves at load+10P+0.5
    task automatic frame(input logic [7:0] b, input int p, input bit idle_after, input string preq);
        int cnt = 0;
        while (txd == 1'b0 && cnt < p + 5) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == p, preq, cnt, p);
        repeat (p / 2) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            logic e;
            e = (k < 8) ? b[k] : 1'b1;
            chk(txd == e, (k < 8) ? "R4 data bit LSB first" : "R4 stop bit", int'(txd), int'(e));
            if (k < 8) repeat (p) @(negedge clk);
        end
        repeat (p / 2 - 1) @(negedge clk);
        chk(shift_empty == 1'b0 && txd == 1'b1, "R8 busy through stop bit",
            int'({shift_empty, txd}), 1);
        if (!idle_after)
            chk(hold_empty == 1'b0, "R7 second byte waits", int'(hold_empty), 0);
        @(negedge clk);
        if (idle_after) begin
            chk(shift_empty == 1'b1 && txd == 1'b1, "R8 empty after stop",
                int'({shift_empty, txd}), 3);
        end else begin
            chk(txd == 1'b0 && hold_empty == 1'b1 && shift_empty == 1'b0,
                "R7 back-to-back start", int'({txd, hold_empty, shift_empty}), 2);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_en = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(txd == 1'b1 && hold_empty == 1'b1 && shift_empty == 1'b1 && irq == 1'b1,
            "R1 reset state", int'({txd, hold_empty, shift_empty, irq}), 15);

        // table walk: rates and patterns
        foreach (VEC[i]) begin
            int p;
            @(negedge clk);
            fast    = VEC[i][16];
            divisor = VEC[i][15:8];
            p = (int'(VEC[i][15:8]) + 1) * (VEC[i][16] ? 16 : 64);
            write_idle(VEC[i][7:0]);
            frame(VEC[i][7:0], p, 1'b1, VEC[i][16] ? "R2 fast bit period" : "R3 slow bit period");
        end

        // back-to-back with a third write while full (ignored)
        @(negedge clk);
        fast    = 1'b1;
        divisor = 8'd1;
        write_idle(8'hA5);
        wr_valid = 1'b1;
        wr_data  = 8'h3B;
        fork
            frame(8'hA5, 32, 1'b0, "R2 fast bit period");
            begin
                @(negedge clk);
                wr_data = 8'h5C;
                @(negedge clk);
                wr_valid = 1'b0;
            end
        join
        frame(8'h3B, 32, 1'b1, "R5 ignored write kept held byte");
        repeat (40) @(negedge clk);
        chk(txd == 1'b1 && shift_empty == 1'b1, "R5 no frame from ignored write",
            int'({txd, shift_empty}), 3);

        // abort mid-frame, writes while disabled ignored
        write_idle(8'hC3);
        repeat (96) @(negedge clk);
        tx_en    = 1'b0;
        wr_valid = 1'b1;
        wr_data  = 8'h77;
        @(negedge clk);
        chk(txd == 1'b1 && hold_empty == 1'b1 && shift_empty == 1'b1,
            "R10 abort flushes", int'({txd, hold_empty, shift_empty}), 7);
        @(negedge clk);
        wr_valid = 1'b0;
        tx_en    = 1'b1;
        @(negedge clk);
        chk(hold_empty == 1'b1 && irq == 1'b1, "R10 write while disabled ignored",
            int'({hold_empty, irq}), 3);
        repeat (20) @(negedge clk);
        chk(txd == 1'b1 && shift_empty == 1'b1, "R10 line stays idle after abort",
            int'({txd, shift_empty}), 3);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule